// File: doc/BRIEF.md
# Configurable Edge and Load-Mode Register

This block is a W-bit storage register with a true output and a bitwise-complement output. Two enumerated parameters, fixed at elaboration, shape its behaviour. The first picks which transition of the clock captures data: the low-to-high transition or the high-to-low one. The second picks how the load-enable input works and which level asserts it.

In the two synchronous modes the enable is only looked at on the chosen clock transition, and data is taken in only when the enable is asserted at that moment. In the two asynchronous modes the enable overrides the clock. While it is asserted, the output tracks the data input with no clock needed. When it is released, the output keeps the last value it held. While the enable is released, the register still captures data on every chosen clock transition, like a plain flip-flop.

The register has no reset. Its contents are undefined until the first load or capture. All bits share the one clock and the one enable.

Top module: `cfg_edge_reg`

## Requirements
- R1: `qbar_o` equals the bitwise inverse of `q_o` at all times once a value has been stored.
- R2: With EDGE = EDGE_RISE, only a 0-to-1 transition of `clk_i` can capture `d_i`. A 1-to-0 transition leaves `q_o` unchanged.
- R3: With EDGE = EDGE_FALL, only a 1-to-0 transition of `clk_i` can capture `d_i`. A 0-to-1 transition leaves `q_o` unchanged.
- R4: In the synchronous modes (LOAD_SYNC_HI = 1, LOAD_SYNC_LO = 3), an active clock transition with the enable asserted makes `q_o` equal to the `d_i` present before that transition.
- R5: In the synchronous modes, an active clock transition with the enable deasserted leaves `q_o` unchanged.
- R6: In the synchronous modes, changes of `d_i` or `en_i` between active transitions have no effect on `q_o`.
- R7: In the asynchronous modes (LOAD_ASYNC_HI = 0, LOAD_ASYNC_LO = 2), `q_o` equals `d_i` without any clock transition for as long as the enable is asserted. Clock transitions during that time have no other effect.
- R8: In the asynchronous modes, deasserting the enable leaves `q_o` at the last loaded value. Later `d_i` changes are ignored until the next load or capture.
- R9: In the asynchronous modes, an active clock transition with the enable deasserted captures `d_i` into `q_o`.
- R10: In LOAD_ASYNC_HI and LOAD_SYNC_HI the enable is asserted when `en_i` = 1. In LOAD_ASYNC_LO and LOAD_SYNC_LO it is asserted when `en_i` = 0.
- R11: Every bit of `d_i` is stored in its own position of `q_o`, so alternating bit patterns come out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock; which transition is active is set by EDGE |
| en_i | input | 1 | Load enable; its level and timing are set by MODE |
| d_i | input | W | Data to be stored |
| q_o | output | W | Stored value |
| qbar_o | output | W | Bitwise inverse of the stored value |

## Verification
The bound checker works on the active clock transition. At every such transition it checks the complement relation, the synchronous load-or-hold rule from one transition to the next, and, in the asynchronous modes, that the output equals the data while the enable is asserted. The behaviour between transitions can only be seen in the bench's scenarios. This covers the immediate asynchronous load, holding after the enable is released, and data changes being ignored. The same applies to the inactive transition having no effect and to the active-low polarity. The bench applies one step table to all eight combinations of edge and mode, each running side by side.

// File: rtl/edgereg_pkg.sv
package edgereg_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } clk_edge_e;

  typedef enum logic [1:0] {
    LOAD_ASYNC_HI = 2'd0,
    LOAD_SYNC_HI  = 2'd1,
    LOAD_ASYNC_LO = 2'd2,
    LOAD_SYNC_LO  = 2'd3
  } load_mode_e;

  function automatic logic mode_is_async(load_mode_e m);
    return (m == LOAD_ASYNC_HI) || (m == LOAD_ASYNC_LO);
  endfunction

  function automatic logic mode_is_low(load_mode_e m);
    return (m == LOAD_ASYNC_LO) || (m == LOAD_SYNC_LO);
  endfunction

endpackage

// File: rtl/edgereg_clk_sel.sv
module edgereg_clk_sel
  import edgereg_pkg::*;
#(
  parameter clk_edge_e EDGE = EDGE_RISE
) (
  input  logic clk_i,
  output logic clk_o
);

  // The selected transition always shows up as a rising edge on clk_o.
  generate
    if (EDGE == EDGE_FALL) begin : g_fall
      assign clk_o = ~clk_i;
    end else begin : g_rise
      assign clk_o = clk_i;
    end
  endgenerate

endmodule

// File: rtl/edgereg_en_decode.sv
module edgereg_en_decode
  import edgereg_pkg::*;
#(
  parameter load_mode_e MODE = LOAD_SYNC_HI
) (
  input  logic en_i,
  output logic load_o
);

  // Polarity is folded here, so the storage always sees an active-high load.
  generate
    if (mode_is_low(MODE)) begin : g_low
      assign load_o = ~en_i;
    end else begin : g_high
      assign load_o = en_i;
    end
  endgenerate

endmodule

// File: rtl/edgereg_sync_store.sv
module edgereg_sync_store #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q_r;
    if (load_i) begin
      q_n = d_i;
    end
  end

  always_ff @(posedge clk_i) begin
    q_r <= q_n;
  end

  assign q_o = q_r;

endmodule

// File: rtl/edgereg_async_store.sv
module edgereg_async_store #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] edge_q;
  logic [W-1:0] hold_q;
  logic         edge_newer;

  // Clock-side capture; its value is visible only once edge_newer is set.
  always_ff @(posedge clk_i) begin
    edge_q <= d_i;
  end

  // Load dominates: the flag is forced low while the load is asserted, and
  // is set by the first active edge seen with the load released.
  always_ff @(posedge clk_i or posedge load_i) begin
    if (load_i) begin
      edge_newer <= 1'b0;
    end else begin
      edge_newer <= 1'b1;
    end
  end

  // Transparent while loading, keeps the final value when the load drops.
  always_latch begin
    if (load_i) begin
      hold_q <= d_i;
    end
  end

  always_comb begin
    if (load_i) begin
      q_o = d_i;
    end else if (edge_newer) begin
      q_o = edge_q;
    end else begin
      q_o = hold_q;
    end
  end

endmodule

// File: rtl/cfg_edge_reg.sv
module cfg_edge_reg
  import edgereg_pkg::*;
#(
  parameter int         W    = 1,
  parameter clk_edge_e  EDGE = EDGE_RISE,
  parameter load_mode_e MODE = LOAD_SYNC_HI
) (
  input  logic         clk_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] qbar_o
);

  localparam bit IS_ASYNC = mode_is_async(MODE);

  logic         cap_clk;
  logic         load;
  logic [W-1:0] store_q;

  edgereg_clk_sel #(.EDGE(EDGE)) u_clk_sel (
    .clk_i (clk_i),
    .clk_o (cap_clk)
  );

  edgereg_en_decode #(.MODE(MODE)) u_en_decode (
    .en_i   (en_i),
    .load_o (load)
  );

  generate
    if (IS_ASYNC) begin : g_async
      edgereg_async_store #(.W(W)) u_store (
        .clk_i  (cap_clk),
        .load_i (load),
        .d_i    (d_i),
        .q_o    (store_q)
      );
    end else begin : g_sync
      edgereg_sync_store #(.W(W)) u_store (
        .clk_i  (cap_clk),
        .load_i (load),
        .d_i    (d_i),
        .q_o    (store_q)
      );
    end
  endgenerate

  assign q_o    = store_q;
  assign qbar_o = ~store_q;

endmodule

// File: rtl/cfg_edge_reg_chk.sv
module cfg_edge_reg_chk
  import edgereg_pkg::*;
#(
  parameter int         W    = 1,
  parameter clk_edge_e  EDGE = EDGE_RISE,
  parameter load_mode_e MODE = LOAD_SYNC_HI
) (
  input logic         clk_i,
  input logic         en_i,
  input logic [W-1:0] d_i,
  input logic [W-1:0] q_o,
  input logic [W-1:0] qbar_o
);

  logic act_clk;
  logic en_act;
  logic seen = 1'b0;

  assign act_clk = (EDGE == EDGE_FALL) ? !clk_i : clk_i;
  assign en_act  = mode_is_low(MODE) ? !en_i : en_i;

  // Marks that the register holds a defined value.
  always_ff @(posedge act_clk) begin
    seen <= seen | mode_is_async(MODE) | en_act;
  end

  AST_QBAR_INVERSE: assert property (@(posedge act_clk)
    seen |-> (qbar_o == ~q_o)); // R1

  generate
    if (mode_is_async(MODE)) begin : g_async
      AST_ASYNC_FOLLOW: assert property (@(posedge act_clk)
        en_act |-> (q_o == d_i)); // R7
    end else begin : g_sync
      AST_SYNC_LOAD: assert property (@(posedge act_clk)
        en_act |=> (q_o == $past(d_i))); // R4
      AST_SYNC_HOLD: assert property (@(posedge act_clk)
        (seen && !en_act) |=> (q_o == $past(q_o))); // R5
    end
  endgenerate

endmodule

bind cfg_edge_reg cfg_edge_reg_chk #(.W(W), .EDGE(EDGE), .MODE(MODE)) u_chk (
  .clk_i  (clk_i),
  .en_i   (en_i),
  .d_i    (d_i),
  .q_o    (q_o),
  .qbar_o (qbar_o)
);

// File: tb/cfg_edge_reg_tb.sv
`timescale 1ns/1ps
module cfg_edge_reg_tb;
  import edgereg_pkg::*;

  localparam int W  = 4;
  localparam int NC = 8;   // config g: edge = g/4, mode = g%4
  localparam int NS = 16;

  localparam logic [1:0] K_SET = 2'd0, K_RISE = 2'd1, K_FALL = 2'd2;

  typedef struct packed {
    logic [1:0]   kind;
    logic         act;   // logical enable, before polarity
    logic [W-1:0] data;
  } step_t;

  localparam step_t STEPS [NS] = '{
    '{K_SET,  1'b1, 4'h5}, '{K_RISE, 1'b1, 4'h5}, '{K_FALL, 1'b1, 4'h5},
    '{K_SET,  1'b0, 4'hA}, '{K_RISE, 1'b0, 4'hA}, '{K_FALL, 1'b0, 4'hA},
    '{K_SET,  1'b1, 4'h3}, '{K_SET,  1'b1, 4'hC}, '{K_SET,  1'b0, 4'hC},
    '{K_SET,  1'b0, 4'h6}, '{K_RISE, 1'b1, 4'h9}, '{K_FALL, 1'b0, 4'h2},
    '{K_RISE, 1'b0, 4'h7}, '{K_FALL, 1'b1, 4'hE}, '{K_SET,  1'b1, 4'h1},
    '{K_SET,  1'b0, 4'h1}
  };

  logic clk = 1'b0;
  logic dut_clk = 1'b0;
  logic act = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] q_w  [NC];
  logic [W-1:0] qb_w [NC];
  logic [W-1:0] exp_q [NC];
  logic known [NC];
  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_cfg
    localparam clk_edge_e  E = clk_edge_e'(g / 4);
    localparam load_mode_e M = load_mode_e'(g % 4);
    logic en_pin;
    assign en_pin = mode_is_low(M) ? ~act : act;   // R10
    cfg_edge_reg #(.W(W), .EDGE(E), .MODE(M)) u_dut (
      .clk_i  (dut_clk),
      .en_i   (en_pin),
      .d_i    (data),
      .q_o    (q_w[g]),
      .qbar_o (qb_w[g])
    );
  end

  task automatic check(int g, logic [W-1:0] act_v, logic [W-1:0] exp_v, string tag);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s cfg%0d: got %h expected %h", tag, g, act_v, exp_v);
    end
  endtask

  function automatic string tag_for(int g, logic [1:0] kind, logic a);
    bit fall  = (g >= 4);
    bit async = ((g % 4) % 2) == 0;
    bit low   = (g % 4) >= 2;
    bit act_edge = (kind == K_RISE && !fall) || (kind == K_FALL && fall);
    if (low && a) return "R10";
    if (kind != K_SET && !act_edge) return fall ? "R3" : "R2";
    if (async) begin
      if (a) return "R7";
      return (kind == K_SET) ? "R8" : "R9";
    end
    if (kind == K_SET) return "R6";
    return a ? "R4" : "R5";
  endfunction

  task automatic apply(step_t s);
    act  = s.act;
    data = s.data;
    #1;
    if (s.kind == K_RISE) dut_clk = 1'b1;
    if (s.kind == K_FALL) dut_clk = 1'b0;
    #1;
    for (int g = 0; g < NC; g++) begin
      bit fall  = (g >= 4);
      bit async = ((g % 4) % 2) == 0;
      bit act_edge = (s.kind == K_RISE && !fall) || (s.kind == K_FALL && fall);
      if (async && (s.act || act_edge)) begin
        exp_q[g] = s.data; known[g] = 1'b1;
      end
      if (!async && act_edge && s.act) begin
        exp_q[g] = s.data; known[g] = 1'b1;
      end
      if (known[g]) begin
        check(g, q_w[g], exp_q[g], tag_for(g, s.kind, s.act));
        check(g, qb_w[g], ~q_w[g], "R1");
      end
    end
  endtask

  initial begin
    for (int g = 0; g < NC; g++) begin
      known[g] = 1'b0; exp_q[g] = '0;
    end
    #3;
    for (int i = 0; i < NS; i++) apply(STEPS[i]);

    // R11: alternating patterns through every configuration
    apply('{K_SET,  1'b1, 4'b1010});
    apply('{K_RISE, 1'b1, 4'b1010});
    apply('{K_FALL, 1'b1, 4'b1010});
    for (int g = 0; g < NC; g++) check(g, q_w[g], 4'b1010, "R11");
    apply('{K_SET,  1'b1, 4'b0101});
    apply('{K_RISE, 1'b1, 4'b0101});
    apply('{K_FALL, 1'b1, 4'b0101});
    for (int g = 0; g < NC; g++) check(g, qb_w[g], 4'b1010, "R11");

    // R8: short async pulse, then data wanders with no clock
    apply('{K_SET, 1'b1, 4'hF});
    apply('{K_SET, 1'b0, 4'h0});
    apply('{K_SET, 1'b0, 4'h8});
    for (int g = 0; g < NC; g++)
      if (((g % 4) % 2) == 0) check(g, q_w[g], 4'hF, "R8");
      else check(g, q_w[g], 4'h5, "R6");
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end else if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule